// File: doc/BRIEF.md
# DMA Channel Address and Count Register Set

This block keeps the programmable state of four DMA channels. Each channel has a 16-bit starting address and a 16-bit transfer count. Each value is held twice: a base copy that is kept, and a working copy that changes. A host processor reaches these registers through an 8-bit data port and a 4-bit register index. A two-state byte-pointer machine steers each access to the low byte or to the high byte. The same port carries the mode, the mask and the status of each channel, plus a few command strobes.

The transfer engine reports each finished transfer with a one-cycle strobe and a channel index. It may also flag that an external end-of-process arrived with that transfer. The block steps the working address up or down by one and lowers the working count by one. When the count wraps below zero it raises a terminal-count pulse on the next cycle. End of process then either reloads the working copies from the base copies (autoinitialize) or masks the channel. A sticky status bit records that the channel finished.

Byte-pointer machine states: `PTR_LO` (the next access uses the low byte) and `PTR_HI` (the next access uses the high byte). Transitions:
- `PTR_LO -> PTR_HI` and `PTR_HI -> PTR_LO` on every read or write to index 0..7.
- Any state `-> PTR_LO` on reset, on the master-clear strobe or on the pointer-clear strobe.

Top module: `dma_chan_regs`

## Requirements
- R1: Register index 0..7 selects channel idx[2:1]. idx[0]=0 selects the address and idx[0]=1 selects the count. A write loads the selected byte into both the base and the working copy. A read returns the working copy, so the base copy is never visible on the read port.
- R2: Every read or write to index 0..7 toggles the byte pointer, which starts at the low byte. Reset, a write to index 10 (master clear) and a write to index 9 (pointer clear) return the pointer to the low byte.
- R3: A transfer that finds the working count at 0000h leaves it at FFFFh. One cycle later, tc_o shows a one-cycle pulse on the bit of that channel. A programmed count N therefore gives N+1 transfers before the pulse.
- R4: Each accepted transfer lowers the working count by one. It also moves the working address by one: upward when the channel's decrement bit is 0, downward when it is 1.
- R5: End of process means a count wrap or eop_ext_i high together with the strobe. On end of process, a channel with autoinitialize set copies its base address and base count into the working copies, and its mask bit is left unchanged.
- R6: On end of process, a channel without autoinitialize sets its mask bit.
- R7: A read of index 8 returns {4'b0, done[3:0]}, where done holds one bit per channel. A done bit is set on end of process. All done bits clear on reset, on master clear and after each read of index 8.
- R8: A write to index 12 sets memory-to-memory enable (bit 0) and address hold (bit 1). While both are set, transfers on channel 0 leave its working address unchanged but still lower its count.
- R9: If cpu_we_i and xfer_done_i are high in the same cycle, the write takes effect and the transfer is dropped: no register steps and tc_o stays low.
- R10: Reset and master clear set all four mask bits. A write to index 13 sets (data bit 2 = 1) or clears (data bit 2 = 0) the mask of channel data[1:0]. A write to index 14 clears all masks. A read of index 15 returns {4'hF, mask[3:0]}, and mask_o shows the mask bits.
- R11: A write to index 11 sets the mode of channel data[1:0]: data bit 2 is autoinitialize and data bit 3 is decrement. Master clear also clears the memory-to-memory and hold bits. Reads of index 9..14 return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cpu_we_i | input | 1 | Host write strobe |
| cpu_re_i | input | 1 | Host read strobe |
| cpu_addr_i | input | 4 | Register index |
| cpu_wdata_i | input | 8 | Host write data |
| cpu_rdata_o | output | 8 | Host read data, valid in the same cycle as the read strobe |
| xfer_done_i | input | 1 | One-cycle strobe for a finished transfer |
| xfer_ch_i | input | 2 | Channel of the finished transfer |
| eop_ext_i | input | 1 | External end of process, qualified by xfer_done_i |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |
| mask_o | output | 4 | Channel mask bits |

## Verification
The hardest case to reach from the ports is a count wrap or external end of process on a channel that has autoinitialize set. The block must reload from base copies that differ from the working copies and must leave the mask alone.

To reach it, the random stimulus writes small counts (high byte zero, low byte 0..3). Channels then wrap within a few strobes, while random mode writes toggle autoinitialize and decrement. Directed cases cover the wrap, the address hold and a write colliding with a transfer.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int NCH    = 4;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // host register indices (0..7 are the per-channel address/count bytes)
    localparam logic [3:0] IDX_STATUS  = 4'd8;
    localparam logic [3:0] IDX_PTRCLR  = 4'd9;
    localparam logic [3:0] IDX_MCLR    = 4'd10;
    localparam logic [3:0] IDX_MODE    = 4'd11;
    localparam logic [3:0] IDX_CTRL    = 4'd12;
    localparam logic [3:0] IDX_MASK1   = 4'd13;
    localparam logic [3:0] IDX_MASKCLR = 4'd14;
    localparam logic [3:0] IDX_MASKRD  = 4'd15;

    typedef enum logic {
        PTR_LO = 1'b0,
        PTR_HI = 1'b1
    } ptr_state_t;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr
    import dma_regs_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic access_i,
    input  logic clear_i,
    output logic hi_o
);
    ptr_state_t st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= PTR_LO;
        else       st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = PTR_LO;
        end else if (access_i) begin
            unique case (st_q)
                PTR_LO: st_d = PTR_HI;
                PTR_HI: st_d = PTR_LO;
            endcase
        end
    end

    always_comb hi_o = (st_q == PTR_HI);

    // R2: each byte access flips the pointer
    a_r2_ptr_toggle: assert property (@(posedge clk_i) disable iff (rst_i)
        (access_i && !clear_i) |=> (hi_o != $past(hi_o)));
    // R2: clear strobe lands on the low byte
    a_r2_ptr_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        clear_i |=> !hi_o);
endmodule

// File: rtl/dma_chan_reg.sv
module dma_chan_reg
    import dma_regs_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_addr_i,
    input  logic              wr_cnt_i,
    input  logic              hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              step_i,
    input  logic              hold_i,
    input  logic              dec_i,
    input  logic              reload_i,
    output logic [W-1:0]      cur_addr_o,
    output logic [W-1:0]      cur_cnt_o,
    output logic              wrap_o
);
    logic [W-1:0] base_a_q, base_c_q, cur_a_q, cur_c_q;

    always_comb wrap_o = step_i && (cur_c_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            base_a_q <= '0;
            base_c_q <= '0;
            cur_a_q  <= '0;
            cur_c_q  <= '0;
        end else begin
            if (wr_addr_i) begin
                if (hi_i) begin
                    base_a_q[W-1:BYTE_W] <= wdata_i;
                    cur_a_q[W-1:BYTE_W]  <= wdata_i;
                end else begin
                    base_a_q[BYTE_W-1:0] <= wdata_i;
                    cur_a_q[BYTE_W-1:0]  <= wdata_i;
                end
            end
            if (wr_cnt_i) begin
                if (hi_i) begin
                    base_c_q[W-1:BYTE_W] <= wdata_i;
                    cur_c_q[W-1:BYTE_W]  <= wdata_i;
                end else begin
                    base_c_q[BYTE_W-1:0] <= wdata_i;
                    cur_c_q[BYTE_W-1:0]  <= wdata_i;
                end
            end
            if (reload_i) begin
                cur_a_q <= base_a_q;
                cur_c_q <= base_c_q;
            end else if (step_i) begin
                if (!hold_i) cur_a_q <= dec_i ? cur_a_q - 1'b1 : cur_a_q + 1'b1;
                cur_c_q <= cur_c_q - 1'b1;
            end
        end
    end

    assign cur_addr_o = cur_a_q;
    assign cur_cnt_o  = cur_c_q;

    // R5: reload copies the base values
    a_r5_reload_base: assert property (@(posedge clk_i) disable iff (rst_i)
        reload_i |=> (cur_addr_o == $past(base_a_q) && cur_cnt_o == $past(base_c_q)));
    // R3: count wraps from zero to all ones
    a_r3_count_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !reload_i && cur_cnt_o == '0) |=> (cur_cnt_o == '1));
    // R8: held address does not move
    a_r8_addr_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (step_i && !reload_i && hold_i) |=> $stable(cur_addr_o));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int N_CH  = NCH,
    parameter int WW    = WORD_W
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      cpu_we_i,
    input  logic                      cpu_re_i,
    input  logic [3:0]                cpu_addr_i,
    input  logic [BYTE_W-1:0]         cpu_wdata_i,
    output logic [BYTE_W-1:0]         cpu_rdata_o,
    input  logic                      xfer_done_i,
    input  logic [$clog2(N_CH)-1:0]   xfer_ch_i,
    input  logic                      eop_ext_i,
    output logic [N_CH-1:0]           tc_o,
    output logic [N_CH-1:0]           mask_o
);
    localparam int CH_W = $clog2(N_CH);

    logic            byte_acc, ptr_clr, ptr_hi, xfer_ok, mclr;
    logic [N_CH-1:0] wrap_v, eop_v, ai_q, dec_q, mask_q, stat_q, tc_q;
    logic            m2m_q, hold_q;
    logic [WW-1:0]   cur_a [N_CH];
    logic [WW-1:0]   cur_c [N_CH];

    always_comb begin
        byte_acc = (cpu_we_i || cpu_re_i) && !cpu_addr_i[3];
        mclr     = cpu_we_i && (cpu_addr_i == IDX_MCLR);
        ptr_clr  = mclr || (cpu_we_i && cpu_addr_i == IDX_PTRCLR);
        xfer_ok  = xfer_done_i && !cpu_we_i;
    end

    dma_byte_ptr u_ptr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .access_i (byte_acc),
        .clear_i  (ptr_clr),
        .hi_o     (ptr_hi)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic sel, step, hold, reload;
        always_comb begin
            sel    = cpu_we_i && !cpu_addr_i[3] && (cpu_addr_i[CH_W:1] == CH_W'(g));
            step   = xfer_ok && (xfer_ch_i == CH_W'(g));
            hold   = m2m_q && hold_q && (g == 0);
            eop_v[g] = step && (wrap_v[g] || eop_ext_i);
            reload = eop_v[g] && ai_q[g];
        end

        dma_chan_reg #(.W(WW)) u_reg (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .wr_addr_i  (sel && !cpu_addr_i[0]),
            .wr_cnt_i   (sel && cpu_addr_i[0]),
            .hi_i       (ptr_hi),
            .wdata_i    (cpu_wdata_i),
            .step_i     (step),
            .hold_i     (hold),
            .dec_i      (dec_q[g]),
            .reload_i   (reload),
            .cur_addr_o (cur_a[g]),
            .cur_cnt_o  (cur_c[g]),
            .wrap_o     (wrap_v[g])
        );

        // R6: non-reloading channel gets masked at end of process
        a_r6_mask_on_eop: assert property (@(posedge clk_i) disable iff (rst_i)
            (eop_v[g] && !ai_q[g]) |=> mask_o[g]);
        // R5: reloading channel keeps its mask
        a_r5_mask_kept: assert property (@(posedge clk_i) disable iff (rst_i)
            (eop_v[g] && ai_q[g]) |=> (mask_o[g] == $past(mask_o[g])));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q <= '1;
            stat_q <= '0;
            ai_q   <= '0;
            dec_q  <= '0;
            m2m_q  <= 1'b0;
            hold_q <= 1'b0;
            tc_q   <= '0;
        end else begin
            tc_q <= wrap_v;
            if (mclr) begin
                mask_q <= '1;
                stat_q <= '0;
                m2m_q  <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                if (cpu_we_i && cpu_addr_i == IDX_MODE) begin
                    ai_q[cpu_wdata_i[CH_W-1:0]]  <= cpu_wdata_i[2];
                    dec_q[cpu_wdata_i[CH_W-1:0]] <= cpu_wdata_i[3];
                end
                if (cpu_we_i && cpu_addr_i == IDX_CTRL) begin
                    m2m_q  <= cpu_wdata_i[0];
                    hold_q <= cpu_wdata_i[1];
                end
                if (cpu_we_i && cpu_addr_i == IDX_MASK1)
                    mask_q[cpu_wdata_i[CH_W-1:0]] <= cpu_wdata_i[2];
                if (cpu_we_i && cpu_addr_i == IDX_MASKCLR)
                    mask_q <= '0;
                if (cpu_re_i && cpu_addr_i == IDX_STATUS)
                    stat_q <= '0;
                for (int i = 0; i < N_CH; i++) begin
                    if (eop_v[i]) begin
                        stat_q[i] <= 1'b1;
                        if (!ai_q[i]) mask_q[i] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        logic [WW-1:0] word;
        word = cpu_addr_i[0] ? cur_c[cpu_addr_i[CH_W:1]] : cur_a[cpu_addr_i[CH_W:1]];
        if (!cpu_addr_i[3])
            cpu_rdata_o = ptr_hi ? word[WW-1:BYTE_W] : word[BYTE_W-1:0];
        else if (cpu_addr_i == IDX_STATUS)
            cpu_rdata_o = BYTE_W'(stat_q);
        else if (cpu_addr_i == IDX_MASKRD)
            cpu_rdata_o = {{(BYTE_W-N_CH){1'b1}}, mask_q};
        else
            cpu_rdata_o = '0;
    end

    assign tc_o   = tc_q;
    assign mask_o = mask_q;

    // R3: at most one channel reports terminal count
    a_r3_tc_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(tc_o));
    // R7: status read with no transfer leaves all bits clear
    a_r7_status_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_re_i && cpu_addr_i == IDX_STATUS && !xfer_done_i && !cpu_we_i) |=> (stat_q == '0));
    // R9: a write in the same cycle blocks the transfer
    a_r9_write_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (cpu_we_i && xfer_done_i) |=> (tc_o == '0));
endmodule

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       we, re, xd, ext;
    logic [3:0] addr;
    logic [7:0] wdata, rdata;
    logic [1:0] xch;
    logic [3:0] tc, mask;

    always #4 clk = ~clk;

    dma_chan_regs dut_i (
        .clk_i(clk), .rst_i(rst), .cpu_we_i(we), .cpu_re_i(re), .cpu_addr_i(addr),
        .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .xfer_done_i(xd), .xfer_ch_i(xch),
        .eop_ext_i(ext), .tc_o(tc), .mask_o(mask)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [15:0] m_ba [4], m_bc [4], m_ca [4], m_cc [4];
    logic [3:0]  m_ai, m_dec, m_mask, m_stat;
    logic        m_hi, m_m2m, m_hold;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        we = 0; re = 0; xd = 0; ext = 0; addr = 0; wdata = 0; xch = 0;
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [15:0] v;
        if (a < 8) begin
            v = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
            return m_hi ? v[15:8] : v[7:0];
        end
        if (a == 8)  return {4'b0, m_stat};
        if (a == 15) return {4'hF, m_mask};
        return 8'h00;
    endfunction

    task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
        if (a < 8) begin
            if (a[0]) begin
                if (m_hi) begin m_bc[a[2:1]][15:8] = d; m_cc[a[2:1]][15:8] = d; end
                else      begin m_bc[a[2:1]][7:0]  = d; m_cc[a[2:1]][7:0]  = d; end
            end else begin
                if (m_hi) begin m_ba[a[2:1]][15:8] = d; m_ca[a[2:1]][15:8] = d; end
                else      begin m_ba[a[2:1]][7:0]  = d; m_ca[a[2:1]][7:0]  = d; end
            end
            m_hi = ~m_hi;
        end else if (a == 9) m_hi = 0;
        else if (a == 10) begin m_hi = 0; m_mask = 4'hF; m_stat = 0; m_m2m = 0; m_hold = 0; end
        else if (a == 11) begin m_ai[d[1:0]] = d[2]; m_dec[d[1:0]] = d[3]; end
        else if (a == 12) begin m_m2m = d[0]; m_hold = d[1]; end
        else if (a == 13) m_mask[d[1:0]] = d[2];
        else if (a == 14) m_mask = 0;
    endtask

    // write; with collide set, a transfer strobe rides in the same cycle (R9)
    task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d, input bit collide = 0);
        we = 1; addr = a; wdata = d;
        if (collide) begin xd = 1; xch = 2'(a[2:1] + 1); end
        @(negedge clk);
        if (collide) chk("R9 tc_o after collision", tc, 0);
        idle();
        model_wr(a, d);
    endtask

    task automatic cpu_rd(input logic [3:0] a, input string req);
        re = 1; addr = a;
        #1;
        chk(req, rdata, exp_rd(a));
        @(negedge clk);
        idle();
        if (a < 8) m_hi = ~m_hi;
        if (a == 8) m_stat = 0;
    endtask

    task automatic rd16(input logic [3:0] a, input string req);
        cpu_rd(a, req);
        cpu_rd(a, req);
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        cpu_wr(a, v[7:0]);
        cpu_wr(a, v[15:8]);
    endtask

    task automatic xfer(input logic [1:0] ch, input logic e);
        logic wrap;
        wrap = (m_cc[ch] == 16'h0);
        xd = 1; xch = ch; ext = e;
        @(negedge clk);
        chk("R3 tc_o pulse", tc, wrap ? (4'b1 << ch) : 4'b0);
        idle();
        // R4 / R8 step
        if (!(ch == 0 && m_m2m && m_hold)) m_ca[ch] = m_dec[ch] ? m_ca[ch] - 1 : m_ca[ch] + 1;
        m_cc[ch] = m_cc[ch] - 1;
        if (wrap || e) begin
            m_stat[ch] = 1;
            if (m_ai[ch]) begin m_ca[ch] = m_ba[ch]; m_cc[ch] = m_bc[ch]; end // R5
            else m_mask[ch] = 1;                                               // R6
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        rst = 1;
        for (int i = 0; i < 4; i++) begin m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; end
        m_ai = 0; m_dec = 0; m_mask = 4'hF; m_stat = 0; m_hi = 0; m_m2m = 0; m_hold = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // reset state: R10 masks set, R7 status clear
        chk("R10 mask_o after reset", mask, 4'hF);
        chk("R3 tc_o after reset", tc, 0);
        cpu_rd(8, "R7 status after reset");
        cpu_rd(15, "R10 mask readback after reset");
        rd16(0, "R1 address after reset");

        // R1 program channel 1, R11 mode, R10 unmask
        wr16(2, 16'h1234);
        wr16(3, 16'h0002);
        rd16(2, "R1 address readback");
        cpu_wr(11, 8'h01);
        cpu_wr(13, 8'h01);
        chk("R10 single mask clear", mask, 4'b1101);
        xfer(1, 0); xfer(1, 0); xfer(1, 0);        // R3 third transfer wraps
        rd16(2, "R4 address stepped up");
        rd16(3, "R3 count at FFFF");
        chk("R6 mask set after wrap", mask, 4'b1111);
        cpu_rd(8, "R7 status shows channel 1");
        cpu_rd(8, "R7 status cleared by read");

        // R2 pointer clear
        cpu_wr(4, 8'h5A);
        cpu_wr(9, 8'h00);
        cpu_rd(4, "R2 pointer back to low byte");
        cpu_rd(4, "R2 pointer high byte");

        // R5 autoinit, decrement, wrap on first transfer
        cpu_wr(11, 8'h0E);
        wr16(4, 16'h0100);
        wr16(5, 16'h0000);
        cpu_wr(14, 8'h00);
        xfer(2, 0);
        rd16(4, "R5 address reloaded");
        chk("R5 mask kept clear", mask[2], 1'b0);
        wr16(5, 16'h0005);
        xfer(2, 0);
        rd16(4, "R4 address stepped down");
        xfer(2, 1);
        rd16(5, "R5 count reloaded on external eop");
        cpu_rd(8, "R7 status from external eop");

        // R8 address hold on channel 0
        cpu_wr(12, 8'h03);
        wr16(0, 16'h0050);
        wr16(1, 16'h0004);
        xfer(0, 0);
        rd16(0, "R8 address held");
        rd16(1, "R8 count still stepped");
        cpu_wr(12, 8'h00);
        xfer(0, 0);
        rd16(0, "R8 address moves once hold off");

        // R9 collision: write to channel 2 while channel 3 (count 0) strobes
        cpu_wr(4, 8'h77, 1);
        rd16(6, "R9 dropped transfer left address");
        rd16(7, "R9 dropped transfer left count");

        // R11 master clear
        cpu_wr(4, 8'h11);
        cpu_wr(10, 8'h00);
        chk("R11 master clear masks", mask, 4'hF);
        rd16(4, "R2 pointer low after master clear");
        cpu_rd(12, "R11 unused index reads zero");

        // random phase
        void'($urandom(32'd20240611));
        for (int k = 0; k < 1500; k++) begin
            int op;
            logic [3:0] a;
            op = $urandom % 10;
            case (op)
                0, 1, 2: begin
                    a = 4'($urandom % 8);
                    if (a[0] && m_hi) cpu_wr(a, 8'h00);
                    else if (a[0])    cpu_wr(a, 8'($urandom % 4));
                    else              cpu_wr(a, 8'($urandom));
                end
                3: begin
                    case ($urandom % 4)
                        0: a = 4'd8;
                        1: a = 4'd15;
                        default: a = 4'($urandom % 8);
                    endcase
                    cpu_rd(a, "R1 R7 R10 random readback");
                end
                4: cpu_wr(11, 8'($urandom % 16));
                5, 6, 7: xfer(2'($urandom % 4), ($urandom % 8) == 0);
                8: begin
                    if ($urandom % 30 == 0) cpu_wr(10, 8'h00);
                    else if ($urandom % 4 == 0) cpu_wr(14, 8'h00);
                    else cpu_wr(13, 8'($urandom % 8));
                end
                default: begin
                    if ($urandom % 2 == 0) cpu_wr(12, 8'($urandom % 4));
                    else cpu_wr(9, 8'h00);
                end
            endcase
            if (k % 50 == 0) chk("R10 mask_o random", mask, m_mask);
        end
        summary();
    end
endmodule